// File: doc/BRIEF.md
# Boot-time Configuration Byte Loader

This controller runs as soon as reset is released. It fetches a short image from an external serial memory one byte at a time and places the contents into the device's configuration registers. Bytes are fetched through a request/acknowledge read port. The serial wire protocol lives behind that port, so the loader only sees an address, a request and a returned byte.

The image is guarded by two signature bytes, each equal to A5h. The first guards a 48-bit station address, which is written into both the host-side and the switch-side address registers. The second guards four configuration-strap bytes. When the second signature is wrong, the strap bytes are still fetched, which keeps the read burst unbroken, but they are discarded.

Every full load ends with a request to copy the strap-derived defaults into the PHY registers. That request is acknowledged by a separate management engine. After a load the loader idles. A command pulse starts a new full load. A host soft-reset pulse reloads only the host-side address. `busy` is high whenever any pass is running.

Top module: `cfg_boot_loader`

## Requirements
- R1: When reset is released, `busy` is 1 and the first read requested is address 0.
- R2: In a full load, if byte 0 is not A5h, no address or strap register changes. `phyWrReq` is then raised, and after its acknowledge the loader idles.
- R3: In a full load, if byte 0 is A5h, bytes 1 to 6 are written into both `hostMac` and `switchMac`. Byte 1 goes to bits [7:0] and byte 6 to bits [47:40].
- R4: In a full load, if byte 7 is A5h, bytes 8 to 11 are written into `strapCfg`. Byte 8 goes to [7:0], byte 9 to [15:8], byte 10 to [23:16] and byte 11 to [31:24]. Within bytes 8 and 9, bit 0 is autonegotiation, bit 1 duplex, bit 2 speed, bit 3 auto MDIX, bit 4 manual MDIX, bit 5 manual flow control, bit 6 full-duplex flow control and bit 7 backpressure enable.
- R5: In a full load, if byte 7 is not A5h, addresses 8 to 11 are still read, but `strapCfg` keeps its value.
- R6: Every full load ends with `phyWrReq` held high until `phyWrAck`. `strapCfg` does not change while the request is up.
- R7: A `hostSoftRst` pulse while idle re-reads byte 0. If byte 0 is A5h, bytes 1 to 6 reload `hostMac` only. No strap byte is read, `switchMac` is untouched, and no PHY write is requested.
- R8: `busy` is high from the start to the end of every full load or host reload, and low only while idle.
- R9: `reloadCmd` while idle starts a full load. `reloadCmd` while busy is ignored.
- R10: A `hostSoftRst` pulse that arrives while busy is held pending. The host reload then starts one cycle after the loader returns to idle.
- R11: Reads within a pass use ascending addresses. `rdAddr` holds steady while `rdReq` waits for `rdAck`. Back-to-back acknowledges are accepted.
- R12: If `reloadCmd` and `hostSoftRst` arrive in the same idle cycle, only a full load runs and the soft reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reloadCmd | input | 1 | One-cycle pulse requesting a full load |
| hostSoftRst | input | 1 | One-cycle pulse requesting a host address reload |
| rdReq | output | 1 | Byte read request to the serial memory engine |
| rdAddr | output | ADDR_W | Byte address of the current request |
| rdAck | input | 1 | Read done; `rdData` is valid this cycle |
| rdData | input | 8 | Returned byte |
| phyWrReq | output | 1 | Request to push strap defaults into the PHY registers |
| phyWrAck | input | 1 | PHY write finished |
| busy | output | 1 | Loader pass in progress |
| hostMac | output | 48 | Host-side station address |
| switchMac | output | 48 | Switch-side station address |
| strapCfg | output | 32 | Four configuration-strap bytes |

## Verification
The hardest state to reach is a soft-reset pulse landing in the middle of a full load. The loader must hold that pulse through the rest of the burst and the PHY handshake, dip out of `busy` for exactly one cycle, and then start a host-only pass. A second hard case is a reload pulse that arrives while busy and must leave no trace.

The bench reaches both by firing the pulses a few cycles after a load begins. It varies the read and PHY acknowledge latencies between runs, so the pulses fall in different phases. A behavioural model follows every handshake and is compared on each clock. It counts how often address 0 is fetched, and it records that addresses 8 to 11 were read even when the strap signature is bad.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  localparam int BYTE_W      = 8;
  localparam int MAC_BYTES   = 6;
  localparam int STRAP_BYTES = 4;
  localparam int MAC_FIRST   = 1;
  localparam int MAC_LAST    = MAC_FIRST + MAC_BYTES - 1;
  localparam int FLAG_IDX    = MAC_LAST + 1;
  localparam int STRAP_FIRST = FLAG_IDX + 1;
  localparam int STRAP_LAST  = STRAP_FIRST + STRAP_BYTES - 1;
  localparam int MAC_SEL_W   = $clog2(MAC_BYTES);
  localparam int STRAP_SEL_W = $clog2(STRAP_BYTES);

  typedef enum logic [1:0] {ST_WAIT, ST_READ, ST_PHY} ldrState_t;

  typedef struct packed {
    logic                   macWr;
    logic                   toSwitch;
    logic [MAC_SEL_W-1:0]   macSel;
    logic                   strapWr;
    logic [STRAP_SEL_W-1:0] strapSel;
    logic [BYTE_W-1:0]      data;
  } ldrStrb_t;
endpackage

// File: rtl/cfg_ldr_ctrl.sv
module cfg_ldr_ctrl
  import cfg_ldr_pkg::*;
#(
  parameter int               ADDR_W = 8,
  parameter logic [BYTE_W-1:0] SIG   = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reloadCmd,
  input  logic              hostSoftRst,
  input  logic              rdAck,
  input  logic [BYTE_W-1:0] rdData,
  input  logic              phyWrAck,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              phyWrReq,
  output logic              busy,
  output ldrStrb_t          strb
);
  localparam logic [ADDR_W-1:0] A_MAC0   = ADDR_W'(MAC_FIRST);
  localparam logic [ADDR_W-1:0] A_MACN   = ADDR_W'(MAC_LAST);
  localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(FLAG_IDX);
  localparam logic [ADDR_W-1:0] A_STRAP0 = ADDR_W'(STRAP_FIRST);
  localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(STRAP_LAST);

  ldrState_t         state;
  logic              fullMode;
  logic              strapOk;
  logic              pend;
  logic [ADDR_W-1:0] idx;
  logic              take;

  assign take     = (state == ST_READ) && rdAck;
  assign rdReq    = (state == ST_READ);
  assign rdAddr   = idx;
  assign phyWrReq = (state == ST_PHY);
  assign busy     = (state != ST_WAIT);

  always_comb begin
    strb          = '0;
    strb.data     = rdData;
    strb.toSwitch = fullMode;
    strb.macSel   = MAC_SEL_W'(idx - A_MAC0);
    strb.strapSel = STRAP_SEL_W'(idx - A_STRAP0);
    if (take && idx >= A_MAC0 && idx <= A_MACN) strb.macWr = 1'b1;
    if (take && strapOk && idx >= A_STRAP0 && idx <= A_LAST) strb.strapWr = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_READ;
      fullMode <= 1'b1;
      idx      <= '0;
      strapOk  <= 1'b0;
      pend     <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (reloadCmd || hostSoftRst || pend) begin
            state    <= ST_READ;
            fullMode <= reloadCmd;
            idx      <= '0;
            pend     <= 1'b0;
          end
        end
        ST_READ: begin
          if (hostSoftRst) pend <= 1'b1;
          if (rdAck) begin
            if (idx == '0) begin
              if (rdData != SIG) state <= fullMode ? ST_PHY : ST_WAIT;
              else               idx   <= idx + 1'b1;
            end else if (!fullMode && idx == A_MACN) begin
              state <= ST_WAIT;
            end else if (idx == A_LAST) begin
              state <= ST_PHY;
            end else begin
              if (idx == A_FLAG) strapOk <= (rdData == SIG);
              idx <= idx + 1'b1;
            end
          end
        end
        ST_PHY: begin
          if (hostSoftRst) pend <= 1'b1;
          if (phyWrAck) state <= ST_WAIT;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq && $stable(rdAddr));

  p_phy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    phyWrReq && !phyWrAck |=> phyWrReq);

  p_pend_served_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && pend |=> busy && rdReq && rdAddr == '0);

  p_bad_sig_r2: assert property (@(posedge clk) disable iff (!rstN)
    take && fullMode && idx == '0 && rdData != SIG |=> phyWrReq);
endmodule

// File: rtl/cfg_ldr_dpath.sv
module cfg_ldr_dpath
  import cfg_ldr_pkg::*;
#(
  parameter logic [BYTE_W*STRAP_BYTES-1:0] STRAP_RST = 32'h00FF_2121
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ldrStrb_t                      strb,
  output logic [BYTE_W*MAC_BYTES-1:0]   hostMac,
  output logic [BYTE_W*MAC_BYTES-1:0]   switchMac,
  output logic [BYTE_W*STRAP_BYTES-1:0] strapCfg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostMac   <= '0;
      switchMac <= '0;
      strapCfg  <= STRAP_RST;
    end else begin
      if (strb.macWr) begin
        hostMac[{strb.macSel, 3'b000} +: BYTE_W] <= strb.data;
        if (strb.toSwitch) switchMac[{strb.macSel, 3'b000} +: BYTE_W] <= strb.data;
      end
      if (strb.strapWr) strapCfg[{strb.strapSel, 3'b000} +: BYTE_W] <= strb.data;
    end
  end

  p_switch_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.macWr && !strb.toSwitch |=> $stable(switchMac));
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_ldr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  SIG       = 8'hA5,
  parameter logic [31:0] STRAP_RST = 32'h00FF_2121
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reloadCmd,
  input  logic              hostSoftRst,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [7:0]        rdData,
  output logic              phyWrReq,
  input  logic              phyWrAck,
  output logic              busy,
  output logic [47:0]       hostMac,
  output logic [47:0]       switchMac,
  output logic [31:0]       strapCfg
);
  ldrStrb_t strb;

  cfg_ldr_ctrl #(.ADDR_W(ADDR_W), .SIG(SIG)) u_ctrl (
    .clk(clk), .rstN(rstN), .reloadCmd(reloadCmd), .hostSoftRst(hostSoftRst),
    .rdAck(rdAck), .rdData(rdData), .phyWrAck(phyWrAck),
    .rdReq(rdReq), .rdAddr(rdAddr), .phyWrReq(phyWrReq), .busy(busy), .strb(strb)
  );

  cfg_ldr_dpath #(.STRAP_RST(STRAP_RST)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostMac(hostMac), .switchMac(switchMac), .strapCfg(strapCfg)
  );

  p_straps_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    phyWrReq |=> $stable(strapCfg));
endmodule

// File: tb/sim_cfg_boot_loader.sv
`timescale 1ns/1ps
module sim_cfg_boot_loader;
  localparam logic [31:0] SRST = 32'h00FF_2121;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reloadCmd = 1'b0, hostSoftRst = 1'b0;
  logic rdReq, rdAck = 1'b0, phyWrReq, phyWrAck = 1'b0, busy;
  logic [7:0] rdAddr, rdData = '0;
  logic [47:0] hostMac, switchMac;
  logic [31:0] strapCfg;

  always #2.5 clk = ~clk;

  cfg_boot_loader u0 (
    .clk(clk), .rstN(rstN), .reloadCmd(reloadCmd), .hostSoftRst(hostSoftRst),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .phyWrReq(phyWrReq), .phyWrAck(phyWrAck), .busy(busy),
    .hostMac(hostMac), .switchMac(switchMac), .strapCfg(strapCfg)
  );

  int nChecks = 0, nFail = 0, cycles = 0;
  logic [7:0] mem [16];
  int rdLat = 0, phyLat = 0, rc = 0, pc = 0;
  int reads = 0, addr0Reads = 0;
  bit phySeen = 0;
  bit [15:0] addrSeen = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic setImage(logic [7:0] s0, logic [47:0] mac, logic [7:0] s7, logic [31:0] st);
    mem[0] = s0;
    for (int i = 0; i < 6; i++) mem[1+i] = mac[8*i +: 8];
    mem[7] = s7;
    for (int i = 0; i < 4; i++) mem[8+i] = st[8*i +: 8];
    for (int i = 12; i < 16; i++) mem[i] = 8'hEE;
  endtask

  // serial memory and PHY engine responders
  always @(negedge clk) begin
    if (rdReq && rc >= rdLat) begin rdAck <= 1'b1; rdData <= mem[rdAddr[3:0]]; rc <= 0; end
    else begin rdAck <= 1'b0; rdData <= 8'hxx; if (rdReq) rc <= rc + 1; end
    if (phyWrReq && pc >= phyLat) begin phyWrAck <= 1'b1; pc <= 0; end
    else begin phyWrAck <= 1'b0; if (phyWrReq) pc <= pc + 1; end
  end

  // behavioural reference model
  int mState, mIdx;
  bit mFull, mOk, mPend;
  logic [47:0] eHost, eSwitch;
  logic [31:0] eStrap;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= 1; mFull <= 1; mIdx <= 0; mOk <= 0; mPend <= 0;
      eHost <= '0; eSwitch <= '0; eStrap <= SRST;
    end else if (mState == 0) begin
      if (reloadCmd || hostSoftRst || mPend) begin
        mState <= 1; mFull <= reloadCmd; mIdx <= 0; mPend <= 0;
      end
    end else begin
      if (hostSoftRst) mPend <= 1;
      if (mState == 2 && phyWrAck) mState <= 0;
      if (mState == 1 && rdAck) begin
        if (mIdx == 0) begin
          if (rdData != 8'hA5) mState <= mFull ? 2 : 0; else mIdx <= 1;
        end else if (mIdx <= 6) begin
          eHost[8*(mIdx-1) +: 8] <= rdData;
          if (mFull) eSwitch[8*(mIdx-1) +: 8] <= rdData;
          if (!mFull && mIdx == 6) mState <= 0; else mIdx <= mIdx + 1;
        end else if (mIdx == 7) begin
          mOk <= (rdData == 8'hA5); mIdx <= 8;
        end else begin
          if (mOk) eStrap[8*(mIdx-8) +: 8] <= rdData;
          if (mIdx == 11) mState <= 2; else mIdx <= mIdx + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rstN && rdReq && rdAck) begin
      reads <= reads + 1;
      addrSeen[rdAddr[3:0]] <= 1'b1;
      if (rdAddr == 0) addr0Reads <= addr0Reads + 1;
    end
    if (rstN && phyWrReq) phySeen <= 1;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog R8 actual=busy expected=idle");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rstN) begin
      chk("R8 busy", 64'(busy), 64'(mState != 0));
      chk("R11 rdReq", 64'(rdReq), 64'(mState == 1));
      if (mState == 1) chk("R11 rdAddr", 64'(rdAddr), 64'(mIdx));
      chk("R6 phyWrReq", 64'(phyWrReq), 64'(mState == 2));
      chk("R3 hostMac", 64'(hostMac), 64'(eHost));
      chk("R3 switchMac", 64'(switchMac), 64'(eSwitch));
      chk("R4 strapCfg", 64'(strapCfg), 64'(eStrap));
    end
  end

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic pulse(bit rl, bit sr);
    @(negedge clk); reloadCmd = rl; hostSoftRst = sr;
    @(negedge clk); reloadCmd = 0; hostSoftRst = 0;
  endtask

  task automatic clr();
    reads = 0; addr0Reads = 0; phySeen = 0; addrSeen = '0;
  endtask

  initial begin
    logic [47:0] m1, m2, m3, m4, m5, m6;
    m1 = 48'h665544332211; m2 = 48'hA1B2C3D4E5F6; m3 = 48'h0F0E0D0C0B0A;
    m4 = 48'h123456789ABC; m5 = 48'hCAFE00BEEF01; m6 = 48'h5A5A01020304;
    setImage(8'hA5, m1, 8'hA5, 32'h12345678);
    rdLat = 2; phyLat = 3;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd1);
    chk("R1 first addr", 64'(rdAddr), 64'd0);
    waitIdle();
    chk("R3 host", 64'(hostMac), 64'(m1));
    chk("R3 switch", 64'(switchMac), 64'(m1));
    chk("R4 straps", 64'(strapCfg), 64'h12345678);
    chk("R4 port1 autoneg bit0", 64'(strapCfg[0]), 64'(mem[8][0]));
    chk("R6 phy write seen", 64'(phySeen), 64'd1);

    // bad strap flag, back-to-back acks, reload while busy
    clr(); rdLat = 0; phyLat = 0;
    setImage(8'hA5, m2, 8'h5A, 32'hDEADBEEF);
    pulse(1, 0);
    repeat (3) @(negedge clk);
    pulse(1, 0);
    waitIdle();
    repeat (6) @(negedge clk);
    chk("R9 reload ignored while busy", 64'(addr0Reads), 64'd1);
    chk("R9 idle after", 64'(busy), 64'd0);
    chk("R3 host m2", 64'(hostMac), 64'(m2));
    chk("R5 straps kept", 64'(strapCfg), 64'h12345678);
    chk("R5 strap bytes read", 64'(addrSeen[11:8]), 64'hF);

    // bad header signature
    clr(); rdLat = 1; phyLat = 2;
    setImage(8'h00, m3, 8'hA5, 32'h0BADF00D);
    pulse(1, 0); waitIdle();
    chk("R2 host kept", 64'(hostMac), 64'(m2));
    chk("R2 switch kept", 64'(switchMac), 64'(m2));
    chk("R2 straps kept", 64'(strapCfg), 64'h12345678);
    chk("R2 phy write", 64'(phySeen), 64'd1);
    chk("R2 one read", 64'(reads), 64'd1);

    // host soft reset while idle
    clr();
    setImage(8'hA5, m4, 8'hA5, 32'h44444444);
    pulse(0, 1); waitIdle();
    chk("R7 host reloaded", 64'(hostMac), 64'(m4));
    chk("R7 switch untouched", 64'(switchMac), 64'(m2));
    chk("R7 straps untouched", 64'(strapCfg), 64'h12345678);
    chk("R7 no phy write", 64'(phySeen), 64'd0);
    chk("R7 seven reads", 64'(reads), 64'd7);

    // soft reset with bad signature
    clr();
    setImage(8'h11, m1, 8'hA5, 32'h0);
    pulse(0, 1); waitIdle();
    chk("R7 bad sig host kept", 64'(hostMac), 64'(m4));
    chk("R7 bad sig one read", 64'(reads), 64'd1);

    // soft reset during a full load stays pending
    clr(); rdLat = 1; phyLat = 4;
    setImage(8'hA5, m5, 8'hA5, 32'h55AA55AA);
    pulse(1, 0);
    repeat (4) @(negedge clk);
    pulse(0, 1);
    waitIdle();
    repeat (2) @(negedge clk);
    waitIdle();
    chk("R10 two passes", 64'(addr0Reads), 64'd2);
    chk("R10 host", 64'(hostMac), 64'(m5));
    chk("R10 switch", 64'(switchMac), 64'(m5));
    chk("R10 straps", 64'(strapCfg), 64'h55AA55AA);

    // simultaneous pulses
    clr(); rdLat = 0; phyLat = 1;
    setImage(8'hA5, m6, 8'hA5, 32'h66778899);
    pulse(1, 1); waitIdle();
    repeat (10) @(negedge clk);
    chk("R12 single pass", 64'(addr0Reads), 64'd1);
    chk("R12 switch", 64'(switchMac), 64'(m6));
    chk("R12 idle", 64'(busy), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule